// File: doc/BRIEF.md
# Dynamically Paired Set Cache Directory

This block is the tag side of a set-associative cache that lends spare room from quiet sets to overloaded ones. Each set keeps a small saturation counter that climbs on misses and falls on hits. When a set whose counter is at the top of its range must throw out a valid line to make room, that line is not lost. It is moved into a partner set and marked as displaced.

The partner is not wired in advance. The first time an unpaired, saturated set evicts, it takes a candidate index offered by an external selector. Both sets then record each other in a per-set pairing entry, and the block pulses a strobe to tell the selector that its candidate has been used. From then on, a miss in the set's own lines starts a second probe in the partner. That probe looks only for displaced lines. Every later overflow eviction also goes to the same partner.

Lookups are answered in the same cycle as the request. The directory state (tags, valid, displaced and age bits, counters, pairing entries) changes at the next clock edge.

Top module: `dyn_pair_cache_dir`

## Requirements
- R1: After reset every line is invalid, every counter is 0, and every pairing entry is unpaired with its partner field equal to the set's own index. The first lookup to any set is therefore a plain miss.
- R2: A request hits first when a valid line in the indexed set has an equal tag and its displaced bit clear. `firstHit` is high in the same cycle.
- R3: When the first probe fails and the set is unpaired, the result is `miss`. The requested tag is written as a native line (displaced bit clear) into the set's least recently used way.
- R4: When the first probe fails and the set is paired, a second probe searches the partner set. It matches only a valid line with an equal tag and the displaced bit set, and a match raises `secondHit`. A displaced line never satisfies a first probe.
- R5: The requesting set's counter goes up by one on a miss and down by one on a first or second hit. It saturates at 0 and at 2*WAYS-1.
- R6: A miss that evicts a valid line while the set's counter, before this access's update, equals 2*WAYS-1 displaces that line. The line goes into the least recently used way of the destination set with its displaced bit set, and the destination's old line in that way is lost. A paired set always uses its recorded partner as the destination.
- R7: If such an overflow eviction happens in an unpaired set and the candidate is acceptable, `candTake` pulses in that cycle. The candidate becomes the destination, and both sets' entries become paired, each naming the other.
- R8: A candidate is acceptable only if `candValid` is high, it differs from the requesting set, and it is not already paired. Otherwise the evicted line is dropped, `candTake` stays low and the set stays unpaired.
- R9: `firstHit`, `secondHit` and `miss` depend only on the current request and state. Exactly one of them is high when `reqValid` is high, and all outputs are low when it is low.
- R10: A line that is hit, newly filled, or placed by displacement becomes the most recently used line of its set. The replacement choice is always the least recently used way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request present |
| reqIndex | input | IDX_W | Set index of the request |
| reqTag | input | TAG_W | Tag of the request |
| candValid | input | 1 | Selector offers a destination candidate |
| candIndex | input | IDX_W | Candidate destination set |
| firstHit | output | 1 | Native line found in the indexed set |
| secondHit | output | 1 | Displaced line found in the partner set |
| miss | output | 1 | Neither probe found the line |
| candTake | output | 1 | Candidate consumed for a new pairing |

## Verification
On a single overflow miss the block writes two different sets in the same cycle. It fills the requesting set with the new tag, and it places the evicted line into the destination set, which may also mean recording a new pairing in both entries. The bench forces this by hitting a set until its counter saturates. It then misses it with a candidate offered, with no candidate, and with an unacceptable candidate (the set itself, or a set that is already paired). Each case is judged afterwards through a second probe that must or must not find the moved tag. A behavioural model with queue-based recency compares all four outputs on every request, both in directed sequences and in a long random mix.

// File: rtl/dpcd_pkg.sv
package dpcd_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct packed {
    logic touchA;    // recency update in the requesting set
    logic touchB;    // recency update in the partner/destination set
    logic fill;      // write new native line into requesting set
    logic displace;  // move evicted line into destination set
    logic associate; // record a new pairing in both entries
    logic satUp;
    logic satDown;
  } ctrlStrobes_t;
endpackage

// File: rtl/dpcd_datapath.sv
module dpcd_datapath
  import dpcd_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [IDX_W-1:0] candIndex,
  input  ctrlStrobes_t     ctrl,
  input  logic [IDX_W-1:0] destIdx,
  output logic             firstAny,
  output logic             secondAny,
  output logic             assocFlag,
  output logic [IDX_W-1:0] partner,
  output logic             victimValid,
  output logic             satIsMax,
  output logic             candFree
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SETS    = 1 << IDX_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int SAT_MAX = 2 * WAYS - 1;
  localparam int SAT_W   = $clog2(SAT_MAX + 1);

  logic [TAG_W-1:0] tagMem  [SETS][WAYS];
  logic [WAY_W-1:0] ageMem  [SETS][WAYS];
  logic [WAYS-1:0]  validMem[SETS];
  logic [WAYS-1:0]  dispMem [SETS];
  logic [SAT_W-1:0] satMem  [SETS];
  logic [IDX_W-1:0] partMem [SETS];
  logic [SETS-1:0]  flagMem;

  logic [WAY_W-1:0] firstWay, secondWay, victimWay, destWay, wayA, wayB;
  logic [IDX_W-1:0] setB;
  logic [TAG_W-1:0] victimTag;

  always_comb begin
    firstAny  = 1'b0;
    secondAny = 1'b0;
    firstWay  = '0;
    secondWay = '0;
    victimWay = '0;
    destWay   = '0;
    partner   = partMem[reqIndex];
    for (int w = 0; w < WAYS; w++) begin
      if (validMem[reqIndex][w] && !dispMem[reqIndex][w] && tagMem[reqIndex][w] == reqTag) begin
        firstAny = 1'b1;
        firstWay = WAY_W'(w);
      end
      if (validMem[partner][w] && dispMem[partner][w] && tagMem[partner][w] == reqTag) begin
        secondAny = 1'b1;
        secondWay = WAY_W'(w);
      end
      if (ageMem[reqIndex][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
      if (ageMem[destIdx][w] == WAY_W'(WAYS - 1))  destWay   = WAY_W'(w);
    end
  end

  assign victimValid = validMem[reqIndex][victimWay];
  assign victimTag   = tagMem[reqIndex][victimWay];
  assign satIsMax    = satMem[reqIndex] == SAT_W'(SAT_MAX);
  assign assocFlag   = flagMem[reqIndex];
  assign candFree    = !flagMem[candIndex];

  assign wayA = ctrl.fill ? victimWay : firstWay;
  assign setB = ctrl.displace ? destIdx : partner;
  assign wayB = ctrl.displace ? destWay : secondWay;

  function automatic logic [WAY_W-1:0] agedValue(input logic [WAY_W-1:0] cur,
                                                 input logic [WAY_W-1:0] pivot,
                                                 input logic isTouched);
    if (isTouched)        return '0;
    else if (cur < pivot) return cur + 1'b1;
    else                  return cur;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w] <= '0;
          ageMem[s][w] <= WAY_W'(w);
        end
        validMem[s] <= '0;
        dispMem[s]  <= '0;
        satMem[s]   <= '0;
        partMem[s]  <= IDX_W'(s);
      end
      flagMem <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ctrl.touchA && IDX_W'(s) == reqIndex)
            ageMem[s][w] <= agedValue(ageMem[s][w], ageMem[s][wayA], WAY_W'(w) == wayA);
          else if (ctrl.touchB && IDX_W'(s) == setB)
            ageMem[s][w] <= agedValue(ageMem[s][w], ageMem[s][wayB], WAY_W'(w) == wayB);
        end
      end
      if (ctrl.fill) begin
        tagMem[reqIndex][victimWay]   <= reqTag;
        validMem[reqIndex][victimWay] <= 1'b1;
        dispMem[reqIndex][victimWay]  <= 1'b0;
      end
      if (ctrl.displace) begin
        tagMem[destIdx][destWay]   <= victimTag;
        validMem[destIdx][destWay] <= 1'b1;
        dispMem[destIdx][destWay]  <= 1'b1;
      end
      if (ctrl.associate) begin
        flagMem[reqIndex] <= 1'b1;
        partMem[reqIndex] <= destIdx;
        flagMem[destIdx]  <= 1'b1;
        partMem[destIdx]  <= reqIndex;
      end
      if (ctrl.satUp && !satIsMax)
        satMem[reqIndex] <= satMem[reqIndex] + 1'b1;
      else if (ctrl.satDown && satMem[reqIndex] != '0)
        satMem[reqIndex] <= satMem[reqIndex] - 1'b1;
    end
  end
endmodule

// File: rtl/dpcd_control.sv
module dpcd_control
  import dpcd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic             candValid,
  input  logic [IDX_W-1:0] candIndex,
  input  logic             firstAny,
  input  logic             secondAny,
  input  logic             assocFlag,
  input  logic [IDX_W-1:0] partner,
  input  logic             victimValid,
  input  logic             satIsMax,
  input  logic             candFree,
  output ctrlStrobes_t     ctrl,
  output logic [IDX_W-1:0] destIdx,
  output logic             firstHit,
  output logic             secondHit,
  output logic             miss,
  output logic             candTake
);
  timeunit 1ns;
  timeprecision 100ps;

  logic overflowEvict, candOk;

  assign firstHit  = reqValid && firstAny;
  assign secondHit = reqValid && !firstAny && assocFlag && secondAny;
  assign miss      = reqValid && !firstAny && !(assocFlag && secondAny);

  assign overflowEvict = miss && victimValid && satIsMax;
  assign candOk        = candValid && (candIndex != reqIndex) && candFree;
  assign destIdx       = assocFlag ? partner : candIndex;
  assign candTake      = overflowEvict && !assocFlag && candOk;

  always_comb begin
    ctrl           = '0;
    ctrl.fill      = miss;
    ctrl.touchA    = firstHit || miss;
    ctrl.displace  = overflowEvict && (assocFlag || candOk);
    ctrl.touchB    = secondHit || ctrl.displace;
    ctrl.associate = candTake;
    ctrl.satUp     = miss;
    ctrl.satDown   = firstHit || secondHit;
  end
endmodule

// File: rtl/dyn_pair_cache_dir.sv
module dyn_pair_cache_dir
  import dpcd_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             candValid,
  input  logic [IDX_W-1:0] candIndex,
  output logic             firstHit,
  output logic             secondHit,
  output logic             miss,
  output logic             candTake
);
  timeunit 1ns;
  timeprecision 100ps;

  ctrlStrobes_t     ctrl;
  logic [IDX_W-1:0] destIdx, partner;
  logic             firstAny, secondAny, assocFlag, victimValid, satIsMax, candFree;

  dpcd_datapath #(.IDX_W(IDX_W), .WAYS(WAYS), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqIndex(reqIndex), .reqTag(reqTag),
    .candIndex(candIndex), .ctrl(ctrl), .destIdx(destIdx),
    .firstAny(firstAny), .secondAny(secondAny), .assocFlag(assocFlag),
    .partner(partner), .victimValid(victimValid), .satIsMax(satIsMax),
    .candFree(candFree)
  );

  dpcd_control #(.IDX_W(IDX_W)) u_ctl (
    .reqValid(reqValid), .reqIndex(reqIndex), .candValid(candValid),
    .candIndex(candIndex), .firstAny(firstAny), .secondAny(secondAny),
    .assocFlag(assocFlag), .partner(partner), .victimValid(victimValid),
    .satIsMax(satIsMax), .candFree(candFree), .ctrl(ctrl), .destIdx(destIdx),
    .firstHit(firstHit), .secondHit(secondHit), .miss(miss), .candTake(candTake)
  );
endmodule

// File: rtl/dpcd_checker.sv
module dpcd_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [IDX_W-1:0] reqIndex,
  input logic             candValid,
  input logic [IDX_W-1:0] candIndex,
  input logic             firstHit,
  input logic             secondHit,
  input logic             miss,
  input logic             candTake,
  input logic             pairedNow
);
  timeunit 1ns;
  timeprecision 100ps;

  assert_one_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({firstHit, secondHit, miss}) == 1);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(firstHit || secondHit || miss || candTake));

  assert_take_on_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    candTake |-> (miss && candValid && !pairedNow));

  assert_take_not_self_R8: assert property (@(posedge clk) disable iff (!rstN)
    candTake |-> (candIndex != reqIndex));

  assert_second_needs_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    secondHit |-> pairedNow);
endmodule

bind dyn_pair_cache_dir dpcd_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIndex(reqIndex),
  .candValid(candValid), .candIndex(candIndex), .firstHit(firstHit),
  .secondHit(secondHit), .miss(miss), .candTake(candTake), .pairedNow(assocFlag)
);

// File: tb/dyn_pair_cache_dir_bench.sv
module dyn_pair_cache_dir_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IDX_W   = 3;
  localparam int WAYS    = 2;
  localparam int TAG_W   = 8;
  localparam int SETS    = 1 << IDX_W;
  localparam int SAT_MAX = 2 * WAYS - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [IDX_W-1:0] reqIndex = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic candValid = 1'b0;
  logic [IDX_W-1:0] candIndex = '0;
  logic firstHit, secondHit, miss, candTake;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  dyn_pair_cache_dir #(.IDX_W(IDX_W), .WAYS(WAYS), .TAG_W(TAG_W)) u_dyn_pair_cache_dir (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIndex(reqIndex), .reqTag(reqTag),
    .candValid(candValid), .candIndex(candIndex), .firstHit(firstHit),
    .secondHit(secondHit), .miss(miss), .candTake(candTake)
  );

  // behavioural reference
  int mTag [SETS][WAYS];
  bit mVal [SETS][WAYS];
  bit mDisp[SETS][WAYS];
  int mSat [SETS];
  bit mFlag[SETS];
  int mPart[SETS];
  int order[SETS][$];   // front = most recent

  task automatic modelReset();
    for (int s = 0; s < SETS; s++) begin
      order[s].delete();
      for (int w = 0; w < WAYS; w++) begin
        mTag[s][w] = 0; mVal[s][w] = 0; mDisp[s][w] = 0;
        order[s].push_back(w);
      end
      mSat[s] = 0; mFlag[s] = 0; mPart[s] = s;
    end
  endtask

  task automatic touch(int s, int w);
    for (int i = 0; i < order[s].size(); i++)
      if (order[s][i] == w) begin order[s].delete(i); break; end
    order[s].push_front(w);
  endtask

  task automatic modelStep(input int idx, input int tg, input bit cv, input int ci,
                           output bit eF, output bit eS, output bit eM, output bit eT);
    int fw, sw, p, vw, vt, d, dw;
    bit ok;
    eF = 0; eS = 0; eM = 0; eT = 0;
    fw = -1; sw = -1;
    for (int w = 0; w < WAYS; w++)
      if (mVal[idx][w] && !mDisp[idx][w] && mTag[idx][w] == tg) fw = w;
    if (fw >= 0) begin
      eF = 1; touch(idx, fw);
      if (mSat[idx] > 0) mSat[idx]--;
      return;
    end
    p = mPart[idx];
    if (mFlag[idx])
      for (int w = 0; w < WAYS; w++)
        if (mVal[p][w] && mDisp[p][w] && mTag[p][w] == tg) sw = w;
    if (sw >= 0) begin
      eS = 1; touch(p, sw);
      if (mSat[idx] > 0) mSat[idx]--;
      return;
    end
    eM = 1;
    vw = order[idx][$];
    vt = mTag[idx][vw];
    ok = 0; d = p;
    if (mVal[idx][vw] && mSat[idx] == SAT_MAX) begin
      if (mFlag[idx]) ok = 1;
      else begin
        d = ci;
        ok = cv && (ci != idx) && !mFlag[ci];
        if (ok) begin
          eT = 1;
          mFlag[idx] = 1; mPart[idx] = ci;
          mFlag[ci] = 1;  mPart[ci] = idx;
        end
      end
    end
    mTag[idx][vw] = tg; mVal[idx][vw] = 1; mDisp[idx][vw] = 0; touch(idx, vw);
    if (ok) begin
      dw = order[d][$];
      mTag[d][dw] = vt; mVal[d][dw] = 1; mDisp[d][dw] = 1; touch(d, dw);
    end
    if (mSat[idx] < SAT_MAX) mSat[idx]++;
  endtask

  task automatic check(bit actual, bit expected, string req, string what);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, actual, expected, $time);
    end
  endtask

  // drive at negedge, compare after settling, state updates at next posedge
  task automatic access(bit v, int idx, int tg, bit cv, int ci, string req);
    bit eF, eS, eM, eT;
    @(negedge clk);
    reqValid = v; reqIndex = IDX_W'(idx); reqTag = TAG_W'(tg);
    candValid = cv; candIndex = IDX_W'(ci);
    #1;
    if (v) modelStep(idx, tg, cv, ci, eF, eS, eM, eT);
    else begin eF = 0; eS = 0; eM = 0; eT = 0; end
    check(firstHit,  eF, req, "firstHit");
    check(secondHit, eS, req, "secondHit");
    check(miss,      eM, req, "miss");
    check(candTake,  eT, req, "candTake");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    #1;
    check(firstHit | secondHit | miss | candTake, 1'b0, "R1", "outputs in reset");
    rstN = 1'b1;

    access(1, 0, 8'hA1, 0, 0, "R1");      // cold miss
    access(1, 0, 8'hB2, 1, 6, "R3");      // fill second way
    access(1, 0, 8'hC3, 1, 6, "R5");      // evicts A, counter 2 -> no move
    access(1, 0, 8'hC3, 1, 6, "R2");      // native hit, counter down
    access(1, 0, 8'hD4, 1, 6, "R5");      // evicts B below saturation
    access(1, 0, 8'hC3, 0, 0, "R10");     // C becomes recent
    access(1, 0, 8'hE5, 0, 0, "R10");     // evicts D, keeps C
    access(1, 0, 8'hC3, 0, 0, "R10");     // C must still be present
    access(1, 0, 8'hF6, 0, 0, "R3");      // evicts E, counter to max
    access(1, 0, 8'h17, 0, 0, "R8");      // overflow, no candidate
    access(1, 0, 8'h28, 1, 0, "R8");      // overflow, candidate is self
    access(1, 0, 8'h39, 1, 6, "R7");      // pairing with set 6
    access(1, 0, 8'h17, 0, 0, "R4");      // found in partner
    access(1, 6, 8'h17, 0, 0, "R4");      // displaced copy invisible to first probe
    access(1, 0, 8'h4A, 0, 0, "R6");
    access(1, 0, 8'h5B, 1, 3, "R6");      // paired overflow goes to partner
    access(1, 0, 8'h39, 0, 0, "R6");      // moved line found second
    access(0, 0, 8'h39, 1, 2, "R9");      // idle cycle
    for (int k = 0; k < 5; k++)
      access(1, 2, 8'h60 + k, 1, 6, "R8"); // candidate already paired
    access(1, 2, 8'h62, 0, 0, "R8");       // dropped line gone: plain miss

    for (int n = 0; n < 4000; n++)
      access($urandom_range(0, 9) != 0, $urandom_range(0, SETS - 1),
             $urandom_range(0, 5), $urandom_range(0, 1) == 1,
             $urandom_range(0, SETS - 1), "R9");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule